// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This unit holds the status, interrupt-cause and sequence-step registers of a simple SCSI host controller, together with three transfer-count bytes and a FIFO-flags byte, and drives one level interrupt line. Other logic in the controller reports what happened through single-cycle strobes. A strobe can load cause and step values, run the end-of-transfer action, report a selection that found no target, or report that a command has completed with a given status byte.

Software services an interrupt by reading the interrupt-cause register over a byte-wide register bus. That read returns the cause and clears the interrupt. A completion that arrives while an interrupt is still pending is not allowed to overwrite the unread cause. Its status byte is parked until the host's clearing read. The parked completion is then reported one cycle later and raises the line again.

Top module: `scsi_irq_status`

Register addresses: 0, 1, 2 are the transfer-count bytes (low, middle, high), 4 is status, 5 is interrupt cause, 6 is sequence step, 7 is FIFO flags. Status bit 7 is the interrupt-pending bit and status bit 4 is the count-zero bit. The status-phase value is 0x03, the bus-service cause is 0x10, the disconnect cause is 0x20 and the command-done step code is 0x04.

## Requirements
- R1: After reset every register reads 0x00, `irq` is low and `resp_stat` is 0x00.
- R2: `irq` always equals status bit 7. A request to raise the interrupt while that bit is already 1 leaves `irq` high and does not toggle it.
- R3: A read of address 5 returns the cause value held before the read. On the same edge it zeroes the cause register, clears status bits 7 and 4, loads step 0x04 and drops `irq`.
- R4: With bit 7 clear, a completion strobe reports at once: on the next edge status becomes 0x93, cause 0x10, step 0x00, flags and count bytes 0x00, and `resp_stat` takes the strobe's status byte.
- R5: With bit 7 set, a completion strobe changes no register and leaves `resp_stat` unchanged. The status byte is held and a deferred flag is set.
- R6: A clearing read while a completion is held (or while one arrives in that same cycle) first applies the clear, so `irq` is low for one cycle. On the following edge the held completion is reported as in R4 and the deferred flag drops.
- R7: The transfer-done strobe sets status bits 4 and 7 and keeps the other status bits. It loads cause 0x10 and zeroes step, flags and all count bytes.
- R8: The no-target strobe sets status to 0x80, cause 0x20 and step 0x00, which raises `irq`.
- R9: Writes to addresses 0 to 2 and 7 are stored and read back. A write to any count byte clears status bit 4.
- R10: The load strobe ORs its status bits into status and loads cause and step. It raises `irq` only when its raise flag is 1.
- R11: Reads of addresses other than 5 have no side effect on any register or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, same cycle as `rd_en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| ld_vld | input | 1 | Load strobe |
| ld_stat | input | 8 | Status bits to OR in |
| ld_intr | input | 8 | Cause value to load |
| ld_seq | input | 8 | Step value to load |
| ld_raise | input | 1 | Load strobe also raises the interrupt |
| xdone_vld | input | 1 | Transfer-done strobe |
| nosel_vld | input | 1 | No-target selection strobe |
| cmpl_vld | input | 1 | Command-complete strobe |
| cmpl_stat | input | 8 | Status byte of the completion |
| irq | output | 1 | Level interrupt line |
| resp_stat | output | 8 | Status byte saved for the response |

## Verification
Read data is combinational, so it is due in the same cycle as the read and shows the value from before the read's edge. Every strobe lands on the next clock edge. A held completion appears two edges after its clearing read, with `irq` low in between. The bench drives each stimulus just after a falling edge and compares 1 ns later. A read queued by the driver is therefore popped by the monitor in the same half-cycle, and a strobe's result is checked in the first sample after it, or after two samples for a release.

// File: rtl/isu_pkg.sv
package isu_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned A_STAT  = 4;
  localparam int unsigned A_INTR  = 5;
  localparam int unsigned A_SEQ   = 6;
  localparam int unsigned A_FLAGS = 7;

  localparam int unsigned ST_INT_B = 7;
  localparam int unsigned ST_TCZ_B = 4;

  localparam byte_t ST_PHASE_STATUS = 8'h03;
  localparam byte_t IR_BUSSVC       = 8'h10;
  localparam byte_t IR_DISC         = 8'h20;
  localparam byte_t SEQ_DONE        = 8'h04;
endpackage

// File: rtl/isu_bus_dec.sv
module isu_bus_dec
  import isu_pkg::*;
#(
  parameter int unsigned AW   = 3,
  parameter int unsigned TC_N = 3
) (
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  byte_t                   stat_q,
  input  byte_t                   intr_q,
  input  byte_t                   seq_q,
  input  byte_t                   flags_q,
  input  logic [TC_N-1:0][7:0]    tc_q,
  output logic                    clr_rd,
  output logic [TC_N-1:0]         tc_we,
  output logic                    flags_we,
  output byte_t                   rd_data
);
  // the cause register is the only read with side effects
  assign clr_rd   = rd_en && (rd_addr == AW'(A_INTR));
  assign flags_we = wr_en && (wr_addr == AW'(A_FLAGS));

  for (genvar g = 0; g < TC_N; g++) begin : g_tcwe
    assign tc_we[g] = wr_en && (wr_addr == AW'(g));
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_addr == AW'(A_STAT))       rd_data = stat_q;
      else if (rd_addr == AW'(A_INTR))  rd_data = intr_q;
      else if (rd_addr == AW'(A_SEQ))   rd_data = seq_q;
      else if (rd_addr == AW'(A_FLAGS)) rd_data = flags_q;
      else begin
        for (int i = 0; i < TC_N; i++) begin
          if (rd_addr == AW'(i)) rd_data = tc_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/isu_defer.sv
module isu_defer
  import isu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_l,
  input  logic  cmpl_vld,
  input  byte_t cmpl_stat,
  input  logic  pend,
  input  logic  clr_rd,
  output logic  report,
  output byte_t report_stat,
  output logic  defer_q,
  output logic  rel_q
);
  logic  hold, direct;
  logic  defer_d, rel_d, held_en;
  byte_t held_q;

  assign hold   = cmpl_vld && pend;
  assign direct = cmpl_vld && !pend;

  always_comb begin
    defer_d = defer_q;
    if (clr_rd)    defer_d = 1'b0;
    else if (hold) defer_d = 1'b1;
  end

  // release is delayed one edge so the clear lands first
  assign rel_d   = clr_rd && (defer_q || hold);
  assign held_en = hold;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      defer_q <= 1'b0;
      rel_q   <= 1'b0;
      held_q  <= '0;
    end else begin
      defer_q <= defer_d;
      rel_q   <= rel_d;
      if (held_en) held_q <= cmpl_stat;
    end
  end

  assign report      = rel_q || direct;
  assign report_stat = direct ? cmpl_stat : held_q;
endmodule

// File: rtl/isu_regs.sv
module isu_regs
  import isu_pkg::*;
#(
  parameter int unsigned TC_N = 3
) (
  input  logic                 clk,
  input  logic                 rst_l,
  input  logic                 clr_rd,
  input  logic [TC_N-1:0]      tc_we,
  input  logic                 flags_we,
  input  byte_t                wr_data,
  input  logic                 ld_vld,
  input  byte_t                ld_stat,
  input  byte_t                ld_intr,
  input  byte_t                ld_seq,
  input  logic                 ld_raise,
  input  logic                 xdone_vld,
  input  logic                 nosel_vld,
  input  logic                 report,
  input  byte_t                report_stat,
  output byte_t                stat_q,
  output byte_t                intr_q,
  output byte_t                seq_q,
  output byte_t                flags_q,
  output logic [TC_N-1:0][7:0] tc_q,
  output byte_t                resp_q
);
  byte_t stat_d, intr_d, seq_d, flags_d, resp_d;
  logic [TC_N-1:0][7:0] tc_d;
  logic  done_act, any_tc_we;
  logic  stat_en, intr_en, seq_en, flags_en, resp_en;
  logic [TC_N-1:0] tc_en;

  assign done_act  = report || xdone_vld;
  assign any_tc_we = |tc_we;

  // order: clearing read, bus writes, load, no-target, completion / done
  always_comb begin
    stat_d  = stat_q;
    intr_d  = intr_q;
    seq_d   = seq_q;
    flags_d = flags_q;
    tc_d    = tc_q;
    resp_d  = resp_q;
    if (clr_rd) begin
      intr_d           = '0;
      stat_d[ST_INT_B] = 1'b0;
      stat_d[ST_TCZ_B] = 1'b0;
      seq_d            = SEQ_DONE;
    end
    for (int i = 0; i < TC_N; i++) begin
      if (tc_we[i]) begin
        tc_d[i]          = wr_data;
        stat_d[ST_TCZ_B] = 1'b0;
      end
    end
    if (flags_we) flags_d = wr_data;
    if (ld_vld) begin
      stat_d = stat_d | ld_stat;
      intr_d = ld_intr;
      seq_d  = ld_seq;
      if (ld_raise) stat_d[ST_INT_B] = 1'b1;
    end
    if (nosel_vld) begin
      stat_d           = '0;
      intr_d           = IR_DISC;
      seq_d            = '0;
      stat_d[ST_INT_B] = 1'b1;
    end
    if (report) begin
      stat_d = ST_PHASE_STATUS;
      resp_d = report_stat;
    end
    if (done_act) begin
      stat_d[ST_TCZ_B] = 1'b1;
      intr_d           = IR_BUSSVC;
      seq_d            = '0;
      flags_d          = '0;
      tc_d             = '0;
      stat_d[ST_INT_B] = 1'b1;
    end
  end

  assign stat_en  = clr_rd || any_tc_we || ld_vld || nosel_vld || done_act;
  assign intr_en  = clr_rd || ld_vld || nosel_vld || done_act;
  assign seq_en   = clr_rd || ld_vld || nosel_vld || done_act;
  assign flags_en = flags_we || done_act;
  assign resp_en  = report;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      stat_q  <= '0;
      intr_q  <= '0;
      seq_q   <= '0;
      flags_q <= '0;
      resp_q  <= '0;
    end else begin
      if (stat_en)  stat_q  <= stat_d;
      if (intr_en)  intr_q  <= intr_d;
      if (seq_en)   seq_q   <= seq_d;
      if (flags_en) flags_q <= flags_d;
      if (resp_en)  resp_q  <= resp_d;
    end
  end

  for (genvar g = 0; g < TC_N; g++) begin : g_tc
    assign tc_en[g] = tc_we[g] || done_act;
    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l)         tc_q[g] <= '0;
      else if (tc_en[g])  tc_q[g] <= tc_d[g];
    end
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import isu_pkg::*;
#(
  parameter int unsigned AW   = 3,
  parameter int unsigned TC_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          ld_vld,
  input  logic [7:0]    ld_stat,
  input  logic [7:0]    ld_intr,
  input  logic [7:0]    ld_seq,
  input  logic          ld_raise,
  input  logic          xdone_vld,
  input  logic          nosel_vld,
  input  logic          cmpl_vld,
  input  logic [7:0]    cmpl_stat,
  output logic          irq,
  output logic [7:0]    resp_stat
);
  logic [1:0] rst_sync;
  logic       rst_l;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  byte_t stat_q, intr_q, seq_q, flags_q, report_stat;
  logic [TC_N-1:0][7:0] tc_q;
  logic clr_rd, flags_we, report, defer_q, rel_q;
  logic [TC_N-1:0] tc_we;

  isu_bus_dec #(.AW(AW), .TC_N(TC_N)) u_dec (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .stat_q   (stat_q),
    .intr_q   (intr_q),
    .seq_q    (seq_q),
    .flags_q  (flags_q),
    .tc_q     (tc_q),
    .clr_rd   (clr_rd),
    .tc_we    (tc_we),
    .flags_we (flags_we),
    .rd_data  (rd_data)
  );

  isu_defer u_defer (
    .clk         (clk),
    .rst_l       (rst_l),
    .cmpl_vld    (cmpl_vld),
    .cmpl_stat   (cmpl_stat),
    .pend        (stat_q[ST_INT_B]),
    .clr_rd      (clr_rd),
    .report      (report),
    .report_stat (report_stat),
    .defer_q     (defer_q),
    .rel_q       (rel_q)
  );

  isu_regs #(.TC_N(TC_N)) u_regs (
    .clk         (clk),
    .rst_l       (rst_l),
    .clr_rd      (clr_rd),
    .tc_we       (tc_we),
    .flags_we    (flags_we),
    .wr_data     (wr_data),
    .ld_vld      (ld_vld),
    .ld_stat     (ld_stat),
    .ld_intr     (ld_intr),
    .ld_seq      (ld_seq),
    .ld_raise    (ld_raise),
    .xdone_vld   (xdone_vld),
    .nosel_vld   (nosel_vld),
    .report      (report),
    .report_stat (report_stat),
    .stat_q      (stat_q),
    .intr_q      (intr_q),
    .seq_q       (seq_q),
    .flags_q     (flags_q),
    .tc_q        (tc_q),
    .resp_q      (resp_stat)
  );

  assign irq = stat_q[ST_INT_B];
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk (
  input logic       clk,
  input logic       rst_l,
  input logic       clr_rd,
  input logic       defer_q,
  input logic       rel_q,
  input logic       irq,
  input logic [7:0] resp_stat,
  input logic [7:0] intr_q,
  input logic [7:0] seq_q,
  input logic       cmpl_vld,
  input logic [7:0] cmpl_stat,
  input logic       nosel_vld,
  input logic       ld_vld,
  input logic       xdone_vld
);
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_l)
    irq && !clr_rd |=> irq); // R2

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_l)
    clr_rd && !cmpl_vld && !nosel_vld && !ld_vld && !xdone_vld && !rel_q
      |=> !irq && intr_q == 8'h00 && seq_q == 8'h04); // R3

  AST_DIRECT_RPT: assert property (@(posedge clk) disable iff (!rst_l)
    cmpl_vld && !irq |=> irq && intr_q == 8'h10 && resp_stat == $past(cmpl_stat)); // R4

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_l)
    cmpl_vld && irq && !clr_rd |=> defer_q && $stable(resp_stat)); // R5

  AST_RELEASE_GO: assert property (@(posedge clk) disable iff (!rst_l)
    clr_rd && defer_q |=> rel_q && !defer_q); // R6

  AST_RELEASE_RAISE: assert property (@(posedge clk) disable iff (!rst_l)
    rel_q |=> irq && intr_q == 8'h10 && seq_q == 8'h00); // R6

  AST_NOSEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_l)
    nosel_vld && !cmpl_vld && !rel_q && !xdone_vld
      |=> irq && intr_q == 8'h20 && seq_q == 8'h00); // R8
endmodule

bind scsi_irq_status scsi_irq_status_chk u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .clr_rd    (clr_rd),
  .defer_q   (defer_q),
  .rel_q     (rel_q),
  .irq       (irq),
  .resp_stat (resp_stat),
  .intr_q    (intr_q),
  .seq_q     (seq_q),
  .cmpl_vld  (cmpl_vld),
  .cmpl_stat (cmpl_stat),
  .nosel_vld (nosel_vld),
  .ld_vld    (ld_vld),
  .xdone_vld (xdone_vld)
);

// File: tb/sim_scsi_irq_status.sv
`timescale 1ns/1ps
module sim_scsi_irq_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_en, wr_en, ld_vld, ld_raise, xdone_vld, nosel_vld, cmpl_vld;
  logic [2:0] rd_addr, wr_addr;
  logic [7:0] wr_data, ld_stat, ld_intr, ld_seq, cmpl_stat, rd_data, resp_stat;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  scsi_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_vld(ld_vld), .ld_stat(ld_stat), .ld_intr(ld_intr), .ld_seq(ld_seq),
    .ld_raise(ld_raise), .xdone_vld(xdone_vld), .nosel_vld(nosel_vld),
    .cmpl_vld(cmpl_vld), .cmpl_stat(cmpl_stat), .irq(irq), .resp_stat(resp_stat)
  );

  task automatic cyc();
    @(negedge clk);
    rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ld_vld = 0; ld_stat = 0; ld_intr = 0; ld_seq = 0; ld_raise = 0;
    xdone_vld = 0; nosel_vld = 0; cmpl_vld = 0; cmpl_stat = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    rd_en = 1; rd_addr = a;
    x.val = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, e);
    end
  endtask

  // monitor: pops expected read data in the cycle of the read
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_en) begin
        if (sb.size() == 0) chk(rd_data, 8'hxx, "scoreboard empty");
        else begin
          exp_t x;
          x = sb.pop_front();
          chk(rd_data, x.val, x.tag);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(); wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic rd1(input logic [2:0] a, input logic [7:0] e, input string tag);
    cyc(); rd(a, e, tag);
  endtask

  task automatic irq_is(input logic e, input string tag);
    cyc(); #1; chk({7'd0, irq}, {7'd0, e}, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    cyc();
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R1 reset state (cause read last: it loads the step code)
    rd1(4, 8'h00, "R1 status");
    rd1(6, 8'h00, "R1 step");
    rd1(7, 8'h00, "R1 flags");
    rd1(0, 8'h00, "R1 tc0");
    rd1(1, 8'h00, "R1 tc1");
    rd1(2, 8'h00, "R1 tc2");
    rd1(5, 8'h00, "R1 cause");
    #1; chk(resp_stat, 8'h00, "R1 resp");
    chk({7'd0, irq}, 8'h00, "R1 irq");

    // R9 writes read back
    wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'h56); wr(7, 8'h07);
    rd1(0, 8'h12, "R9 tc0");
    rd1(1, 8'h34, "R9 tc1");
    rd1(2, 8'h56, "R9 tc2");
    rd1(7, 8'h07, "R9 flags");

    // R10 load without raise
    cyc(); ld_vld = 1; ld_stat = 8'h10; ld_intr = 8'h00; ld_seq = 8'h01;
    rd1(4, 8'h10, "R10 status ORed");
    rd1(6, 8'h01, "R10 step loaded");
    irq_is(1'b0, "R10 no raise");
    // R9 count write clears count-zero bit
    wr(1, 8'h99);
    rd1(4, 8'h00, "R9 tcz cleared");

    // R7 transfer done
    cyc(); xdone_vld = 1;
    rd1(4, 8'h90, "R7 status");
    rd1(6, 8'h00, "R7 step");
    rd1(7, 8'h00, "R7 flags");
    rd1(0, 8'h00, "R7 tc0");
    rd1(1, 8'h00, "R7 tc1");
    rd1(2, 8'h00, "R7 tc2");
    irq_is(1'b1, "R7 irq");
    rd1(5, 8'h10, "R3 old cause");
    cyc(); rd(4, 8'h00, "R3 status cleared"); #1; chk({7'd0, irq}, 8'h00, "R3 irq low");
    rd1(6, 8'h04, "R3 step done");
    rd1(5, 8'h00, "R3 cause zero");

    // R8 no target
    cyc(); nosel_vld = 1;
    rd1(4, 8'h80, "R8 status");
    rd1(6, 8'h00, "R8 step");
    irq_is(1'b1, "R8 irq");
    rd1(7, 8'h00, "R11 flags read");
    cyc(); rd(4, 8'h80, "R11 status intact"); #1; chk({7'd0, irq}, 8'h01, "R11 irq intact");

    // R5 completion while pending
    cyc(); cmpl_vld = 1; cmpl_stat = 8'h02;
    cyc(); rd(4, 8'h80, "R5 status held"); #1; chk(resp_stat, 8'h00, "R5 resp unchanged");
    rd1(6, 8'h00, "R5 step unchanged");
    irq_is(1'b1, "R5 irq");

    // R2 raise while set
    cyc(); ld_vld = 1; ld_intr = 8'h08; ld_seq = 8'h02; ld_raise = 1;
    cyc(); rd(4, 8'h80, "R2 status"); #1; chk({7'd0, irq}, 8'h01, "R2 irq stays");
    rd1(6, 8'h02, "R2 step");

    // R6 release on clearing read
    rd1(5, 8'h08, "R3 cause returned");
    cyc(); rd(4, 8'h00, "R6 cleared first"); #1; chk({7'd0, irq}, 8'h00, "R6 irq gap");
    cyc(); rd(4, 8'h93, "R6 report status"); #1; chk({7'd0, irq}, 8'h01, "R6 irq raised");
    chk(resp_stat, 8'h02, "R6 resp");

    // R4 direct completion
    rd1(5, 8'h10, "R4 prior cause");
    cyc(); cmpl_vld = 1; cmpl_stat = 8'h05;
    cyc(); rd(4, 8'h93, "R4 status"); #1; chk(resp_stat, 8'h05, "R4 resp");
    chk({7'd0, irq}, 8'h01, "R4 irq");
    rd1(6, 8'h00, "R4 step");

    // R6 completion arriving with the clearing read
    cyc(); rd(5, 8'h10, "R6 same-cycle cause"); cmpl_vld = 1; cmpl_stat = 8'h22;
    cyc(); #1; chk({7'd0, irq}, 8'h00, "R6 same-cycle gap"); chk(resp_stat, 8'h05, "R6 resp old");
    cyc(); #1; chk({7'd0, irq}, 8'h01, "R6 same-cycle raise"); chk(resp_stat, 8'h22, "R6 resp new");

    // R10 load without raise after clear
    rd1(5, 8'h10, "R10 clear");
    cyc(); ld_vld = 1; ld_intr = 8'h08;
    irq_is(1'b0, "R10 irq low");
    rd1(5, 8'h08, "R10 cause loaded");

    cyc();
    if (sb.size() != 0) chk(8'(sb.size()), 8'h00, "scoreboard leftover");
    finish_run();
  end
endmodule